// File: doc/BRIEF.md
# Change-of-State Interrupt Detector

This block watches a set of already-synchronized input lines, grouped into banks of equal width, and records every level change that its bank is armed to see. Each bank has an independent rising-edge arm and falling-edge arm, held together in one enable byte: the lower nibble arms rising detection per bank and the upper nibble arms falling detection. Detections latch into a sticky status word that the host reads whole or bytewise, and clears by writing ones back under per-byte strobes.

A registered interrupt request stays high while any status bit is set. A status word of zero tells the host that this block did not raise the interrupt. A soft reset empties the status and re-captures the current line levels as the comparison baseline, so no change is reported for lines that already differ from the old baseline.

Top module: `cos_detector`

## Requirements
- R1: After `rst_n` is low, `status` is all zeros, `irq` is 0 and `en_rdata` is 0.
- R2: A 0-to-1 change on a line, seen by comparing its current value with its value one cycle earlier, sets that line's status bit at the same clock edge when enable bit n (rising arm for bank n) is 1.
- R3: A 1-to-0 change on a line sets its status bit when enable bit n+4 (falling arm for bank n) is 1.
- R4: A change whose direction is not armed for its bank leaves the status unchanged.
- R5: A status bit stays set until cleared, even after the line returns to its earlier level.
- R6: A write with `clr_we[b]` high clears each bit of byte b whose `clr_data` bit is 1; bits written as 0, and bytes whose strobe is low, keep their value.
- R7: When a detection and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: `irq` is the OR of all status bits, delayed by one clock.
- R9: A cycle with `soft_rst` high clears all status bits and loads the current inputs as baseline, so the next cycle reports no change for lines that kept their value.
- R10: Bank n covers status and input bits 8n to 8n+7; bank 0 is the lowest byte and bank 3 the highest.
- R11: `en_rdata` returns the enable byte last written with `en_we`, taking effect the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous status clear and baseline reload |
| line_in | input | 32 | Synchronized input lines, bank n in bits 8n+7:8n |
| en_we | input | 1 | Enable byte write strobe |
| en_wdata | input | 8 | Enable byte: bits 3:0 rising arms, bits 7:4 falling arms |
| en_rdata | output | 8 | Current enable byte |
| clr_we | input | 4 | Per-byte strobes for the status clear write |
| clr_data | input | 32 | Write-one-to-clear data for the status |
| status | output | 32 | Sticky change-of-state status word |
| irq | output | 1 | Level interrupt request |

## Verification
A vector table walks the lines through rising changes, falling changes and returns to a previous level while the enable byte moves between rising-only, both-edge and disarmed banks, so a swapped arm nibble or a wrong bank slice shows up as a missing or extra bit. Clear writes use partial strobes and mixed zero and one data, separating honest write-one-to-clear from whole-word or strobe-blind clears, and one row collides a clear with a fresh change to expose the wrong priority. Directed steps then change many lines in the same cycle as a soft reset, which separates a baseline reload from a mere status clear, and the interrupt is compared every cycle against the previous expected status to pin its one-cycle delay.

// File: rtl/cos_pkg.sv
package cos_pkg;
   localparam int unsigned COS_LANES_DEF = 8;
   localparam int unsigned COS_BANKS_DEF = 4;
endpackage

// File: rtl/cos_edge_bank.sv
module cos_edge_bank #(
   parameter int unsigned LANES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic [LANES-1:0] din,
   input  logic             rise_arm,
   input  logic             fall_arm,
   output logic [LANES-1:0] hit
);
   logic [LANES-1:0] base_q;
   logic [LANES-1:0] up_chg;
   logic [LANES-1:0] dn_chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base_q <= '0;
      else        base_q <= din;
   end

   assign up_chg = din & ~base_q;
   assign dn_chg = ~din & base_q;

   always_comb begin
      hit = '0;
      if (!soft_rst) begin
         if (rise_arm) hit = hit | up_chg;
         if (fall_arm) hit = hit | dn_chg;
      end
   end
endmodule

// File: rtl/cos_status_reg.sv
module cos_status_reg #(
   parameter int unsigned LANES = 8,
   parameter int unsigned BANKS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   soft_rst,
   input  logic [BANKS*LANES-1:0] set_vec,
   input  logic [BANKS-1:0]       clr_we,
   input  logic [BANKS*LANES-1:0] clr_data,
   output logic [BANKS*LANES-1:0] status
);
   localparam int unsigned W = BANKS * LANES;
   logic [W-1:0] wipe;
   logic [W-1:0] st_q;

   for (genvar b = 0; b < BANKS; b++) begin : g_wipe
      assign wipe[b*LANES +: LANES] = clr_we[b] ? clr_data[b*LANES +: LANES] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        st_q <= '0;
      else if (soft_rst) st_q <= '0;
      else               st_q <= (st_q & ~wipe) | set_vec;
   end

   assign status = st_q;
endmodule

// File: rtl/cos_detector.sv
module cos_detector #(
   parameter int unsigned LANES = cos_pkg::COS_LANES_DEF,
   parameter int unsigned BANKS = cos_pkg::COS_BANKS_DEF
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   soft_rst,
   input  logic [BANKS*LANES-1:0] line_in,
   input  logic                   en_we,
   input  logic [2*BANKS-1:0]     en_wdata,
   output logic [2*BANKS-1:0]     en_rdata,
   input  logic [BANKS-1:0]       clr_we,
   input  logic [BANKS*LANES-1:0] clr_data,
   output logic [BANKS*LANES-1:0] status,
   output logic                   irq
);
   localparam int unsigned W  = BANKS * LANES;
   localparam int unsigned EW = 2 * BANKS;

   if (LANES < 1)  begin : g_bad_lanes  $error("LANES must be at least 1");  end
   if (BANKS < 1)  begin : g_bad_banks  $error("BANKS must be at least 1");  end

   logic [EW-1:0] arm_q;
   logic [W-1:0]  set_vec;
   logic          irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     arm_q <= '0;
      else if (en_we) arm_q <= en_wdata;
   end
   assign en_rdata = arm_q;

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      cos_edge_bank #(.LANES(LANES)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .soft_rst (soft_rst),
         .din      (line_in[b*LANES +: LANES]),
         .rise_arm (arm_q[b]),
         .fall_arm (arm_q[b+BANKS]),
         .hit      (set_vec[b*LANES +: LANES])
      );
   end

   cos_status_reg #(.LANES(LANES), .BANKS(BANKS)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .set_vec  (set_vec),
      .clr_we   (clr_we),
      .clr_data (clr_data),
      .status   (status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |status;
   end
   assign irq = irq_q;
endmodule

// File: rtl/cos_detector_chk.sv
module cos_detector_chk #(
   parameter int unsigned LANES = 8,
   parameter int unsigned BANKS = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   soft_rst,
   input logic [2*BANKS-1:0]     en_rdata,
   input logic [BANKS-1:0]       clr_we,
   input logic [BANKS*LANES-1:0] clr_data,
   input logic [BANKS*LANES-1:0] status,
   input logic                   irq
);
   logic [BANKS*LANES-1:0] wipe_m;
   for (genvar b = 0; b < BANKS; b++) begin : g_m
      assign wipe_m[b*LANES +: LANES] = clr_we[b] ? clr_data[b*LANES +: LANES] : '0;
   end

   p_irq_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == $past(|status)));

   p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_rst |=> ((($past(status) & ~$past(wipe_m)) & ~status) == '0));

   p_soft_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (status == '0));

   for (genvar b = 0; b < BANKS; b++) begin : g_off
      p_disarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !(en_rdata[b] || en_rdata[b+BANKS]) |=>
            ((status[b*LANES +: LANES] & ~$past(status[b*LANES +: LANES])) == '0));
   end
endmodule

bind cos_detector cos_detector_chk #(.LANES(LANES), .BANKS(BANKS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .soft_rst (soft_rst),
   .en_rdata (en_rdata),
   .clr_we   (clr_we),
   .clr_data (clr_data),
   .status   (status),
   .irq      (irq)
);

// File: tb/tb_cos_detector.sv
module tb_cos_detector;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic [31:0] line_in = '0;
   logic        en_we = 1'b0;
   logic [7:0]  en_wdata = '0;
   logic [7:0]  en_rdata;
   logic [3:0]  clr_we = '0;
   logic [31:0] clr_data = '0;
   logic [31:0] status;
   logic        irq;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   cos_detector dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .line_in(line_in),
      .en_we(en_we), .en_wdata(en_wdata), .en_rdata(en_rdata),
      .clr_we(clr_we), .clr_data(clr_data), .status(status), .irq(irq)
   );

   typedef struct packed {
      logic [31:0] din;
      logic        ewe;
      logic [7:0]  eval;
      logic [3:0]  cwe;
      logic [31:0] cdat;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{32'h0000_0000, 1'b1, 8'h11, 4'h0, 32'h0,          32'h0000_0000}, // arm bank0 both
      '{32'h0000_0005, 1'b0, 8'h00, 4'h0, 32'h0,          32'h0000_0005}, // R2 rise
      '{32'h0000_0005, 1'b0, 8'h00, 4'h1, 32'h0000_0001,  32'h0000_0004}, // R6 clear bit0
      '{32'h0000_0004, 1'b0, 8'h00, 4'h0, 32'h0,          32'h0000_0005}, // R3 fall
      '{32'h0000_0100, 1'b1, 8'h02, 4'h0, 32'h0,          32'h0000_0005}, // R4 bank1 off, R5
      '{32'h0000_0000, 1'b0, 8'h00, 4'hF, 32'hFFFF_FFFF,  32'h0000_0000}, // R4 fall unarmed, R6
      '{32'h0000_0200, 1'b0, 8'h00, 4'h0, 32'h0,          32'h0000_0200}, // R2 R10 bank1
      '{32'h0000_0201, 1'b1, 8'hFF, 4'h0, 32'h0,          32'h0000_0200}, // R4 bank0 disarmed
      '{32'h0100_0000, 1'b0, 8'h00, 4'h2, 32'hFFFF_FFFF,  32'h0100_0201}, // R7 R10 R3
      '{32'h0100_0000, 1'b0, 8'h00, 4'h8, 32'h00FF_FF01,  32'h0100_0201}, // R6 strobe mask
      '{32'h0100_0000, 1'b0, 8'h00, 4'hF, 32'h0100_0001,  32'h0000_0200}, // R6 partial clear
      '{32'h00FF_0000, 1'b0, 8'h00, 4'h0, 32'h0,          32'h01FF_0200}  // R10 bank2, R3 bank3
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] prev_exp;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 status", status, 32'h0);
      check("R1 irq", {31'h0, irq}, 32'h0);
      check("R1 enable", {24'h0, en_rdata}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      prev_exp = '0;
      for (int i = 0; i < NV; i++) begin
         line_in  = VEC[i].din;
         en_we    = VEC[i].ewe;
         en_wdata = VEC[i].eval;
         clr_we   = VEC[i].cwe;
         clr_data = VEC[i].cdat;
         @(negedge clk);
         check($sformatf("R2/R3/R4/R5/R6/R7/R10 row %0d status", i), status, VEC[i].exp);
         check($sformatf("R8 row %0d irq", i), {31'h0, irq}, {31'h0, |prev_exp});
         prev_exp = VEC[i].exp;
      end
      en_we = 1'b0; clr_we = '0; clr_data = '0;
      check("R11 enable readback", {24'h0, en_rdata}, 32'h0000_00FF);

      // R9: many lines change in the same cycle as the soft reset
      soft_rst = 1'b1;
      line_in  = 32'h0000_00F0;
      @(negedge clk);
      check("R9 status cleared", status, 32'h0);
      check("R8 irq lags clear", {31'h0, irq}, 32'h1);
      soft_rst = 1'b0;
      @(negedge clk);
      check("R9 no change after reload", status, 32'h0);
      check("R8 irq drops", {31'h0, irq}, 32'h0);
      line_in = 32'h0000_00F1;
      @(negedge clk);
      check("R9 detection resumes", status, 32'h0000_0001);
      check("R8 irq not yet", {31'h0, irq}, 32'h0);
      @(negedge clk);
      check("R5 sticky hold", status, 32'h0000_0001);
      check("R8 irq raised", {31'h0, irq}, 32'h1);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule